// File: doc/BRIEF.md
# Serial-Programmed Latch Bank

This block is the three-wire programming port of a dual frequency synthesizer. A host drives a serial clock, a data line and a load strobe. Each rising edge of the serial clock pushes one data bit into a 22-bit word register, most significant bit first. The last two bits of a word are an address. When the load strobe goes high, the upper 20 bits of the word are copied into one of four holding latches, and the address picks which one. The four latch words leave the block in parallel and feed the synthesizer's counters and modes.

All three serial pins are treated as asynchronous to the block clock. Each pin passes through a synchronizer chain, and its edges are found on the block clock. A monitor output shows one of four sources. Two bits in latch 0 choose the source: the top bit of the word register (a serial echo), a lock flag, a counter tap, or constant low.

Top module: `serial_latch_bank`

## Requirements
- R1: While rst_ni is low, the word register and all four latches are zero, so latches_o is all zeros and mon_o is low.
- R2: On each rising edge of sclk_i while le_i is low, the word register shifts left by one and takes sdata_i into bit 0. The first bit sent therefore ends up at bit 21 after 22 edges.
- R3: A rising edge of le_i writes exactly one latch, selected by word bits [1:0]: 00 writes latch 0, 01 latch 1, 10 latch 2 and 11 latch 3. The other three latches keep their values.
- R4: The written latch receives word bits [21:2]. Latch k appears on latches_o[20*k+19 : 20*k].
- R5: When more than 22 bits are shifted in before a load, only the last 22 bits take part in the load.
- R6: Latches change only on a rising edge of le_i. Keeping le_i high, or lowering it, writes nothing more.
- R7: Serial clock edges that occur while le_i is high do not shift the word register.
- R8: When latch 0 bits [1:0] are 00, mon_o equals word register bit 21, and it follows that bit as new bits are shifted in.
- R9: When latch 0 bits [1:0] are 01, mon_o follows lock_i. When they are 10, it follows cnt_i. When they are 11, mon_o is low whatever lock_i and cnt_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock used to sample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; bits shift on its rising edge |
| sdata_i | input | 1 | Serial data, most significant bit first |
| le_i | input | 1 | Load strobe; its rising edge commits the word |
| lock_i | input | 1 | Lock flag offered to the monitor |
| cnt_i | input | 1 | Counter tap offered to the monitor |
| latches_o | output | 80 | Four 20-bit latch words, latch 0 in the low bits |
| mon_o | output | 1 | Monitor output |

## Verification
The bench loads every address with a distinct pattern. A decode that is off by one, or that writes more than one latch, leaves a stale or clobbered word in a neighbouring slot. It overfills the register with extra leading bits and toggles the serial clock while the strobe is high. A design that keeps stale high bits, or that keeps shifting during a load, commits the wrong payload on the next strobe. Finally it walks the monitor select through all four codes, driving lock_i and cnt_i against the expected source. A reversed select encoding, or a constant-low code that leaks a live input, shows up as a mismatch on mon_o.

// File: rtl/slb_pkg.sv
package slb_pkg;
  typedef enum logic [1:0] {
    MON_ECHO = 2'd0,
    MON_LOCK = 2'd1,
    MON_CNT  = 2'd2,
    MON_LOW  = 2'd3
  } mon_sel_e;
endpackage

// File: rtl/slb_sync.sv
module slb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/slb_edge.sv
module slb_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic level;
  logic prev_q;

  slb_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .q_o   (level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level;
  end

  assign level_o = level;
  assign rise_o  = level & ~prev_q;
endmodule

// File: rtl/slb_shift.sv
module slb_shift #(
  parameter int WORD_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  // MSB first: oldest bit drifts toward the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= '0;
    else if (shift_en_i) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/slb_latches.sv
module slb_latches #(
  parameter int WORD_W = 22,
  parameter int ADDR_W = 2,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int NUM_L = 1 << ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [WORD_W-1:0]      word_i,
  output logic [NUM_L*PAY_W-1:0] latches_o
);
  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  payload;

  assign addr    = word_i[ADDR_W-1:0];
  assign payload = word_i[WORD_W-1:ADDR_W];

  for (genvar k = 0; k < NUM_L; k++) begin : g_latch
    logic [PAY_W-1:0] lat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   lat_q <= '0;
      else if (load_i && (addr == ADDR_W'(k)))       lat_q <= payload;
    end
    assign latches_o[k*PAY_W +: PAY_W] = lat_q;
  end
endmodule

// File: rtl/slb_monitor.sv
module slb_monitor
  import slb_pkg::*;
(
  input  mon_sel_e sel_i,
  input  logic     echo_i,
  input  logic     lock_i,
  input  logic     cnt_i,
  output logic     mon_o
);
  always_comb begin
    unique case (sel_i)
      MON_ECHO: mon_o = echo_i;
      MON_LOCK: mon_o = lock_i;
      MON_CNT:  mon_o = cnt_i;
      default:  mon_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank
  import slb_pkg::*;
#(
  parameter int WORD_W      = 22,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MON_LSB     = 0,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int NUM_L = 1 << ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   le_i,
  input  logic                   lock_i,
  input  logic                   cnt_i,
  output logic [NUM_L*PAY_W-1:0] latches_o,
  output logic                   mon_o
);
  logic              sclk_level, sclk_rise;
  logic              le_level, le_rise;
  logic              data_bit;
  logic              shift_en;
  logic [WORD_W-1:0] sreg;
  mon_sel_e          mon_sel;

  slb_edge #(.STAGES(SYNC_STAGES)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sclk_i),
    .level_o(sclk_level),
    .rise_o (sclk_rise)
  );

  slb_edge #(.STAGES(SYNC_STAGES)) u_le (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (le_i),
    .level_o(le_level),
    .rise_o (le_rise)
  );

  // data gets the same latency as the clock so it stays aligned
  slb_sync #(.STAGES(SYNC_STAGES)) u_data (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sdata_i),
    .q_o   (data_bit)
  );

  assign shift_en = sclk_rise & ~le_level;

  slb_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .bit_i     (data_bit),
    .word_o    (sreg)
  );

  slb_latches #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_latches (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (le_rise),
    .word_i   (sreg),
    .latches_o(latches_o)
  );

  assign mon_sel = mon_sel_e'(latches_o[MON_LSB +: 2]);

  slb_monitor u_mon (
    .sel_i (mon_sel),
    .echo_i(sreg[WORD_W-1]),
    .lock_i(lock_i),
    .cnt_i (cnt_i),
    .mon_o (mon_o)
  );

  logic unused_level;
  assign unused_level = sclk_level;
endmodule

// File: rtl/serial_latch_bank_chk.sv
module serial_latch_bank_chk #(
  parameter int WORD_W  = 22,
  parameter int ADDR_W  = 2,
  parameter int MON_LSB = 0,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int NUM_L = 1 << ADDR_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sclk_rise,
  input logic                   le_level,
  input logic                   le_rise,
  input logic                   data_bit,
  input logic [WORD_W-1:0]      sreg,
  input logic [NUM_L*PAY_W-1:0] latches_o,
  input logic                   mon_o
);
  logic [WORD_W-1:0]      prev_sreg;
  logic                   prev_load;
  logic [NUM_L*PAY_W-1:0] prev_lat;
  int                     n_changed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sreg <= '0;
      prev_load <= 1'b0;
      prev_lat  <= '0;
    end else begin
      prev_sreg <= sreg;
      prev_load <= le_rise;
      prev_lat  <= latches_o;
    end
  end

  always_comb begin
    n_changed = 0;
    for (int k = 0; k < NUM_L; k++)
      if (latches_o[k*PAY_W +: PAY_W] != prev_lat[k*PAY_W +: PAY_W]) n_changed++;
  end

  // R2
  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && !le_level) |=> sreg == {$past(sreg[WORD_W-2:0]), $past(data_bit)});

  // R7
  a_r7_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_rise && !le_level) |=> $stable(sreg));

  // R3
  a_r3_one_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_changed <= 1);

  // R4
  a_r4_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_load |-> latches_o[prev_sreg[ADDR_W-1:0]*PAY_W +: PAY_W] == prev_sreg[WORD_W-1:ADDR_W]);

  // R6
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_rise |=> $stable(latches_o));

  // R9
  a_r9_mon_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latches_o[MON_LSB +: 2] == 2'b11) |-> !mon_o);
endmodule

bind serial_latch_bank serial_latch_bank_chk #(
  .WORD_W (WORD_W),
  .ADDR_W (ADDR_W),
  .MON_LSB(MON_LSB)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_rise(sclk_rise),
  .le_level (le_level),
  .le_rise  (le_rise),
  .data_bit (data_bit),
  .sreg     (sreg),
  .latches_o(latches_o),
  .mon_o    (mon_o)
);

// File: tb/serial_latch_bank_bench.sv
module serial_latch_bank_bench;
  localparam int WORD_W = 22;
  localparam int PAY_W  = 20;
  localparam int NL     = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sclk, sdata, le, lock, cnt;
  wire [NL*PAY_W-1:0] latches;
  wire                mon;

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] m_sreg;
  logic [PAY_W-1:0]  m_lat [NL];
  logic              m_le;
  logic              busy;

  serial_latch_bank u_serial_latch_bank (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sclk_i   (sclk),
    .sdata_i  (sdata),
    .le_i     (le),
    .lock_i   (lock),
    .cnt_i    (cnt),
    .latches_o(latches),
    .mon_o    (mon)
  );

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_vec(string req, logic [PAY_W-1:0] act, logic [PAY_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_mon();
    case (m_lat[0][1:0])
      2'd0:    return m_sreg[WORD_W-1];
      2'd1:    return lock;
      2'd2:    return cnt;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_mon(string req);
    checks++;
    if (mon !== exp_mon()) begin
      errors++;
      $display("FAIL %s mon actual %b expected %b", req, mon, exp_mon());
    end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < NL; k++) check_vec(req, latches[k*PAY_W +: PAY_W], m_lat[k]);
    check_mon(req);
  endtask

  task automatic sclk_bit(logic b);
    sdata = b;
    wait_clk(4);
    sclk = 1'b1;
    if (!m_le) m_sreg = {m_sreg[WORD_W-2:0], b};
    wait_clk(4);
    sclk = 1'b0;
    wait_clk(4);
  endtask

  task automatic send_word(logic [WORD_W-1:0] w);
    for (int i = WORD_W - 1; i >= 0; i--) sclk_bit(w[i]);
  endtask

  task automatic le_high();
    busy = 1'b1;
    le   = 1'b1;
    m_le = 1'b1;
    m_lat[m_sreg[1:0]] = m_sreg[WORD_W-1:2];
    wait_clk(6);
    busy = 1'b0;
  endtask

  task automatic le_low();
    le   = 1'b0;
    m_le = 1'b0;
    wait_clk(6);
  endtask

  task automatic load(logic [WORD_W-1:0] w);
    send_word(w);
    le_high();
    le_low();
  endtask

  // R6: latches match the model on every settled clock
  always @(negedge clk) begin
    if (rst_n && !busy)
      for (int k = 0; k < NL; k++) check_vec("R6 hold", latches[k*PAY_W +: PAY_W], m_lat[k]);
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    busy = 1'b1;
    rst_n = 1'b0; sclk = 1'b0; sdata = 1'b0; le = 1'b0; lock = 1'b0; cnt = 1'b0;
    m_sreg = '0; m_le = 1'b0;
    for (int k = 0; k < NL; k++) m_lat[k] = '0;
    wait_clk(3);
    check_all("R1 reset");
    rst_n = 1'b1;
    wait_clk(2);
    busy = 1'b0;

    // R2 R3 R4: one word per address
    load({20'hA5C3E, 2'b01});
    check_all("R2 R4 addr1");
    load({20'h12340, 2'b00});
    check_all("R3 addr0");
    load({20'hFEDCB, 2'b10});
    check_all("R3 addr2");
    load({20'h0F0F1, 2'b11});
    check_all("R3 addr3");

    // R5: extra leading bits are dropped
    for (int i = 0; i < 8; i++) sclk_bit(1'b1);
    load({20'h5A5A5, 2'b10});
    check_all("R5 overfill");

    // R7: clock edges during a load do not shift
    le_high();
    for (int i = 0; i < 5; i++) sclk_bit(1'b1);
    check_mon("R7 echo during load");
    le_low();
    le_high();
    le_low();
    check_all("R6 R7 reload");

    // R8: echo follows the top bit while shifting
    sclk_bit(1'b1); check_mon("R8 echo");
    sclk_bit(0);    check_mon("R8 echo");
    sclk_bit(1'b0); check_mon("R8 echo");
    sclk_bit(1'b1); check_mon("R8 echo");

    // R9: remaining monitor sources
    load({20'h00001, 2'b00});
    lock = 1'b1; wait_clk(1); check_mon("R9 lock");
    lock = 1'b0; wait_clk(1); check_mon("R9 lock");
    load({20'h00002, 2'b00});
    cnt = 1'b1; wait_clk(1); check_mon("R9 cnt");
    cnt = 1'b0; wait_clk(1); check_mon("R9 cnt");
    load({20'h00003, 2'b00});
    lock = 1'b1; cnt = 1'b1; wait_clk(1); check_mon("R9 low");
    check_all("R9 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule